// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block holds the interrupt control state of a small accumulator processor that uses 16-bit words and 12-bit addresses. It keeps the pending-interrupt flag, the interrupt enable, the address, program counter and temporary registers, and a step counter. At every instruction boundary, marked by a start strobe, it chooses one of two paths. It either runs a three-step ordinary fetch, which is only a stub here, or runs a three-step interrupt entry. The interrupt entry writes the return address to memory word 0 and leaves the program counter at 1, where the handler begins.

The block also runs the return-from-interrupt instruction as one two-cycle operation. The enable is set again and the program counter is reloaded from word 0 inside that single operation. Because of this, a device request that is still pending cannot enter the handler again between the enable and the jump back. Enable-on and enable-off pulses from the surrounding execute logic act on the enable flag directly. The memory port is single-ported, with a combinational read.

Top module: `intr_seq`

## Requirements
- R1: The pending flag `r_o` is set at a clock edge only when no fetch step is in progress (`fetch_act` = 0), `ien_o` is 1, and at least one of `dev_in_flag` or `dev_out_flag` is 1. It stays at 1 until the last interrupt step clears it.
- R2: When `cyc_start` is seen while the sequencer is idle and `r_o` is 1, three interrupt steps run (`intr_act` = 1 for three cycles) and no fetch step runs.
- R3: In the second interrupt step, `mem_we` is 1 for exactly one cycle with `mem_addr` = 0. `mem_wdata` carries the program counter value held at the start of the interrupt, zero-extended to 16 bits.
- R4: After the third interrupt step, `pc_o` = 1, `ien_o` = 0 and `r_o` = 0.
- R5: The return instruction starts only when `exec_req` = 1 and `instr_word` = 16'hF020 while the sequencer is idle. Any other word leaves the enable, the program counter and the sequencer unchanged.
- R6: A return takes two cycles. The request cycle sets `ien_o` to 1 and the address to 0. In the following cycle (`reti_act` = 1, `mem_re` = 1) the low 12 bits of memory word 0 are loaded into `pc_o`.
- R7: `ion_pulse` sets `ien_o` and `iof_pulse` clears it, and off wins when both arrive together. The clear from the third interrupt step overrides either pulse. The set from a return overrides either pulse.
- R8: When `cyc_start` is seen while idle with `r_o` = 0, three fetch steps run (`fetch_act` = 1). In the first step the address is loaded from `pc_o`. In the second step `mem_re` = 1 at that address and `pc_o` is incremented.
- R9: Reset (synchronous, active high) clears the enable, the pending flag, the program counter, the address, the temporary register and the step counter, and leaves the sequencer idle.
- R10: The sequencer goes back to idle after the third fetch or interrupt step and after the second return cycle. At most one of `fetch_act`, `intr_act` and `reti_act` is 1 at a time. `cyc_start` outside idle is ignored, and in idle it takes priority over a return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_in_flag | input | 1 | Input device requests service |
| dev_out_flag | input | 1 | Output device requests service |
| cyc_start | input | 1 | Start of an instruction cycle |
| exec_req | input | 1 | Execute logic presents `instr_word` for execution |
| instr_word | input | 16 | Instruction word being executed |
| ion_pulse | input | 1 | Enable interrupts |
| iof_pulse | input | 1 | Disable interrupts |
| mem_rdata | input | 16 | Memory read data (same-cycle) |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_o | output | 12 | Program counter |
| ien_o | output | 1 | Interrupt enable flag |
| r_o | output | 1 | Interrupt pending flag |
| fetch_act | output | 1 | A fetch step is in progress |
| intr_act | output | 1 | An interrupt step is in progress |
| reti_act | output | 1 | Second cycle of a return |

## Verification
A bad sequencer state shows up at the ports one cycle after the edge that corrupts it. It appears as two activity flags high together, as a write strobe outside the second interrupt step, or as a write to a nonzero address. A wrong enable or pending flag is visible within one cycle on `ien_o`/`r_o`. It also changes which path the next `cyc_start` takes, so the wrong path is visible one cycle after that strobe. A bad program counter or temporary value shows first as a wrong saved word on `mem_wdata` during the write cycle, and then as a wrong `pc_o` after a return.

// File: rtl/intr_seq_pkg.sv
`timescale 1ns/100ps
package intr_seq_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int STEP_W  = 2;
    localparam int LAST_ST = 2;
    localparam logic [WORD_W-1:0] RETI_CODE = 16'hF020;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_INTR  = 2'd2,
        PH_RETI  = 2'd3
    } phase_e;

    typedef struct packed {
        logic ar_clr;
        logic ar_ld_pc;
        logic tr_ld_pc;
        logic pc_clr;
        logic pc_inc;
        logic pc_ld_mem;
        logic mem_we;
        logic mem_re;
        logic ien_set;
        logic ien_clr;
        logic r_clr;
    } ctrl_t;

    function automatic logic is_reti(input logic [WORD_W-1:0] w);
        return w == RETI_CODE;
    endfunction
endpackage

// File: rtl/intr_step_ctl.sv
`timescale 1ns/100ps
module intr_step_ctl
    import intr_seq_pkg::*;
#(
    parameter int STEP_W  = 2,
    parameter int LAST_ST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              reti_go,
    input  logic              r_flag,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output ctrl_t             ctrl
);
    localparam logic [STEP_W-1:0] LAST = LAST_ST[STEP_W-1:0];
    localparam logic [STEP_W-1:0] S0   = '0;
    localparam logic [STEP_W-1:0] S1   = STEP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= S0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (cyc_start) begin
                        phase <= r_flag ? PH_INTR : PH_FETCH;
                        step  <= S0;
                    end else if (reti_go) begin
                        phase <= PH_RETI;
                        step  <= S1;
                    end
                end
                PH_FETCH, PH_INTR: begin
                    if (step == LAST) begin
                        phase <= PH_IDLE;
                        step  <= S0;
                    end else begin
                        step <= step + S1;
                    end
                end
                PH_RETI: begin
                    phase <= PH_IDLE;
                    step  <= S0;
                end
                default: begin
                    phase <= PH_IDLE;
                    step  <= S0;
                end
            endcase
        end
    end

    always_comb begin
        ctrl = '0;
        unique case (phase)
            PH_IDLE: begin
                if (!cyc_start && reti_go) begin
                    ctrl.ar_clr  = 1'b1;
                    ctrl.ien_set = 1'b1;
                end
            end
            PH_FETCH: begin
                if (step == S0) ctrl.ar_ld_pc = 1'b1;
                if (step == S1) begin
                    ctrl.mem_re = 1'b1;
                    ctrl.pc_inc = 1'b1;
                end
            end
            PH_INTR: begin
                if (step == S0) begin
                    ctrl.ar_clr   = 1'b1;
                    ctrl.tr_ld_pc = 1'b1;
                end
                if (step == S1) begin
                    ctrl.mem_we = 1'b1;
                    ctrl.pc_clr = 1'b1;
                end
                if (step == LAST) begin
                    ctrl.pc_inc  = 1'b1;
                    ctrl.ien_clr = 1'b1;
                    ctrl.r_clr   = 1'b1;
                end
            end
            PH_RETI: begin
                ctrl.mem_re    = 1'b1;
                ctrl.pc_ld_mem = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/intr_req_flag.sv
`timescale 1ns/100ps
module intr_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic fetch_busy,
    input  logic ien,
    input  logic dev_in,
    input  logic dev_out,
    input  logic clr,
    output logic pend
);
    logic want;
    assign want = !fetch_busy && ien && (dev_in || dev_out);

    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (clr)  pend <= 1'b0;
        else if (want) pend <= 1'b1;
    end
endmodule

// File: rtl/intr_regs.sv
`timescale 1ns/100ps
module intr_regs
    import intr_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              ion,
    input  logic              iof,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ar,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] tr,
    output logic              ien
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ar  <= '0;
            pc  <= '0;
            tr  <= '0;
            ien <= 1'b0;
        end else begin
            if (ctrl.ar_clr)        ar <= '0;
            else if (ctrl.ar_ld_pc) ar <= pc;

            if (ctrl.tr_ld_pc) tr <= DATA_W'(pc);

            if (ctrl.pc_clr)         pc <= '0;
            else if (ctrl.pc_inc)    pc <= pc + ONE;
            else if (ctrl.pc_ld_mem) pc <= rdata[ADDR_W-1:0];

            if (ctrl.ien_clr)      ien <= 1'b0;
            else if (ctrl.ien_set) ien <= 1'b1;
            else if (iof)          ien <= 1'b0;
            else if (ion)          ien <= 1'b1;
        end
    end
endmodule

// File: rtl/intr_seq.sv
`timescale 1ns/100ps
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int DATA_W = intr_seq_pkg::WORD_W,
    parameter int ADDR_W = intr_seq_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_in_flag,
    input  logic              dev_out_flag,
    input  logic              cyc_start,
    input  logic              exec_req,
    input  logic [DATA_W-1:0] instr_word,
    input  logic              ion_pulse,
    input  logic              iof_pulse,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ien_o,
    output logic              r_o,
    output logic              fetch_act,
    output logic              intr_act,
    output logic              reti_act
);
    phase_e             phase;
    logic [STEP_W-1:0]  step;
    ctrl_t              ctrl;
    logic               reti_go;
    logic [ADDR_W-1:0]  ar_q;
    logic [DATA_W-1:0]  tr_q;

    assign reti_go = exec_req && is_reti(16'(instr_word));

    intr_step_ctl #(.STEP_W(STEP_W), .LAST_ST(LAST_ST)) u_ctl (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .reti_go(reti_go),
        .r_flag(r_o), .phase(phase), .step(step), .ctrl(ctrl)
    );

    intr_req_flag u_req (
        .clk(clk), .rst(rst), .fetch_busy(fetch_act), .ien(ien_o),
        .dev_in(dev_in_flag), .dev_out(dev_out_flag), .clr(ctrl.r_clr),
        .pend(r_o)
    );

    intr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ion(ion_pulse), .iof(iof_pulse),
        .rdata(mem_rdata), .ar(ar_q), .pc(pc_o), .tr(tr_q), .ien(ien_o)
    );

    assign fetch_act = (phase == PH_FETCH);
    assign intr_act  = (phase == PH_INTR);
    assign reti_act  = (phase == PH_RETI);
    assign mem_addr  = ar_q;
    assign mem_wdata = tr_q;
    assign mem_we    = ctrl.mem_we;
    assign mem_re    = ctrl.mem_re;
endmodule

// File: rtl/intr_seq_chk.sv
`timescale 1ns/100ps
module intr_seq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_in_flag,
    input logic              dev_out_flag,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc_o,
    input logic              ien_o,
    input logic              r_o,
    input logic              fetch_act,
    input logic              intr_act,
    input logic              reti_act
);
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(r_o) |-> ($past(ien_o) && $past(dev_in_flag || dev_out_flag) && !$past(fetch_act))); // R1
    AST_INTR_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_act) |-> $past(r_o)); // R2
    AST_SAVE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (intr_act && mem_addr == '0)); // R3
    AST_SAVE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R3
    AST_HANDLER_VECTOR: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_act) |-> (pc_o == ADDR_W'(1) && !ien_o && !r_o)); // R4
    AST_RETI_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(reti_act) |-> (ien_o && mem_addr == '0)); // R6
    AST_RETI_SHORT: assert property (@(posedge clk) disable iff (rst)
        reti_act |=> !reti_act); // R6
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_act, intr_act, reti_act})); // R10
endmodule

bind intr_seq intr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .dev_in_flag(dev_in_flag), .dev_out_flag(dev_out_flag),
    .mem_we(mem_we), .mem_addr(mem_addr), .pc_o(pc_o), .ien_o(ien_o), .r_o(r_o),
    .fetch_act(fetch_act), .intr_act(intr_act), .reti_act(reti_act)
);

// File: tb/sim_intr_seq.sv
`timescale 1ns/100ps
module sim_intr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fi = 1'b0, fo = 1'b0, cs = 1'b0, ex = 1'b0, ion = 1'b0, iof = 1'b0;
    logic [15:0] iw = 16'h0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we, mem_re;
    logic [11:0] pc_o;
    logic        ien_o, r_o, fetch_act, intr_act, reti_act;

    logic [15:0] mem [0:4095];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int          m_ph, m_st;
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_tr;
    logic        m_ien, m_r;

    always #2.5 clk = ~clk;

    intr_seq u0 (
        .clk(clk), .rst(rst), .dev_in_flag(fi), .dev_out_flag(fo),
        .cyc_start(cs), .exec_req(ex), .instr_word(iw),
        .ion_pulse(ion), .iof_pulse(iof), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pc_o(pc_o), .ien_o(ien_o), .r_o(r_o),
        .fetch_act(fetch_act), .intr_act(intr_act), .reti_act(reti_act)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Reference model written from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_st <= 0; m_pc <= '0; m_ar <= '0; m_tr <= '0;
            m_ien <= 1'b0; m_r <= 1'b0;
        end else begin
            if (m_ph == 2 && m_st == 2)                   m_r <= 1'b0;
            else if (m_ph != 1 && m_ien && (fi || fo))    m_r <= 1'b1;

            if (m_ph == 2 && m_st == 2)                          m_ien <= 1'b0;
            else if (m_ph == 0 && !cs && ex && iw == 16'hF020)   m_ien <= 1'b1;
            else if (iof)                                        m_ien <= 1'b0;
            else if (ion)                                        m_ien <= 1'b1;

            case (m_ph)
                0: begin
                    if (cs) begin
                        m_ph <= m_r ? 2 : 1; m_st <= 0;
                    end else if (ex && iw == 16'hF020) begin
                        m_ph <= 3; m_st <= 1; m_ar <= '0;
                    end
                end
                1, 2: begin
                    if (m_ph == 1 && m_st == 0) m_ar <= m_pc;
                    if (m_ph == 1 && m_st == 1) m_pc <= m_pc + 12'd1;
                    if (m_ph == 2 && m_st == 0) begin m_ar <= '0; m_tr <= {4'h0, m_pc}; end
                    if (m_ph == 2 && m_st == 1) m_pc <= '0;
                    if (m_ph == 2 && m_st == 2) m_pc <= m_pc + 12'd1;
                    if (m_st == 2) begin m_ph <= 0; m_st <= 0; end
                    else m_st <= m_st + 1;
                end
                default: begin
                    m_pc <= mem[m_ar][11:0];
                    m_ph <= 0; m_st <= 0;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(pc_o == m_pc, "R8 pc vs model", pc_o, m_pc);
        chk(ien_o == m_ien, "R7 ien vs model", ien_o, m_ien);
        chk(r_o == m_r, "R1 pending vs model", r_o, m_r);
        chk(fetch_act == (m_ph == 1), "R10 fetch_act", fetch_act, m_ph == 1);
        chk(intr_act == (m_ph == 2), "R2 intr_act", intr_act, m_ph == 2);
        chk(reti_act == (m_ph == 3), "R6 reti_act", reti_act, m_ph == 3);
        chk(mem_we == (m_ph == 2 && m_st == 1), "R3 mem_we", mem_we, m_ph == 2 && m_st == 1);
        chk(mem_re == ((m_ph == 1 && m_st == 1) || m_ph == 3), "R8 mem_re", mem_re,
            (m_ph == 1 && m_st == 1) || m_ph == 3);
        chk(mem_addr == m_ar, "R6 mem_addr", mem_addr, m_ar);
        if (m_ph == 2 && m_st == 1)
            chk(mem_wdata == m_tr, "R3 mem_wdata", mem_wdata, m_tr);
    endtask

    task automatic cyc(input logic c = 0, input logic e = 0, input logic [15:0] w = 16'h0,
                       input logic on = 0, input logic off = 0,
                       input logic a = 0, input logic b = 0);
        cs = c; ex = e; iw = w; ion = on; iof = off; fi = a; fo = b;
        @(posedge clk);
        @(negedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    logic [11:0] saved;

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk(pc_o == 12'h0 && ien_o == 1'b0 && r_o == 1'b0, "R9 reset regs", {pc_o, ien_o, r_o}, 0);
        chk({fetch_act, intr_act, reti_act, mem_we} == 4'b0, "R9 reset idle",
            {fetch_act, intr_act, reti_act, mem_we}, 0);
        rst = 1'b0;
        cyc();

        // R8 two fetches advance PC to 2
        for (int k = 0; k < 2; k++) begin
            cyc(1);
            chk(fetch_act == 1'b1, "R8 fetch started", fetch_act, 1);
            cyc(); cyc(); cyc();
        end
        chk(pc_o == 12'd2, "R8 pc after two fetches", pc_o, 2);

        // R1 request without enable is not latched
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(r_o == 1'b0, "R1 no latch while disabled", r_o, 0);

        // R1 enable during fetch start; fetch steps suppress latching
        cyc(1, 0, 16'h0, 1, 0, 1, 0);
        chk(ien_o == 1'b1, "R7 ion sets enable", ien_o, 1);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(r_o == 1'b0, "R1 no latch during fetch", r_o, 0);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(r_o == 1'b0 && fetch_act == 1'b0, "R10 back to idle after fetch", r_o, 0);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(r_o == 1'b1, "R1 latch when idle and enabled", r_o, 1);
        saved = pc_o;

        // R2/R3/R4 interrupt entry, ion in RT2 loses
        cyc(1, 0, 16'h0, 0, 0, 1, 0);
        chk(intr_act == 1'b1 && fetch_act == 1'b0, "R2 interrupt replaces fetch", intr_act, 1);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(mem_we == 1'b1 && mem_addr == 12'h0 && mem_wdata == {4'h0, saved},
            "R3 save word at address 0", mem_wdata, saved);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(mem_we == 1'b0 && pc_o == 12'h0, "R3 single write, pc cleared", mem_we, 0);
        chk(mem[0] == {4'h0, saved}, "R3 memory holds return address", mem[0], saved);
        cyc(0, 0, 16'h0, 1, 0, 1, 0);
        chk(pc_o == 12'h1 && ien_o == 1'b0 && r_o == 1'b0, "R4 handler vector", pc_o, 1);
        chk(ien_o == 1'b0, "R7 RT2 clear beats ion", ien_o, 0);

        // R5 non-return word ignored
        cyc(0, 1, 16'hF010, 0, 0, 1, 0);
        chk(reti_act == 1'b0 && ien_o == 1'b0 && pc_o == 12'h1, "R5 other word ignored", reti_act, 0);

        // R6 return with request still pending
        cyc(0, 1, 16'hF020, 0, 1, 1, 0);
        chk(reti_act == 1'b1 && ien_o == 1'b1 && mem_addr == 12'h0 && pc_o == 12'h1,
            "R6 return first cycle", ien_o, 1);
        cyc(0, 0, 16'h0, 0, 0, 1, 0);
        chk(pc_o == saved && reti_act == 1'b0, "R6 pc restored", pc_o, saved);
        chk(r_o == 1'b1, "R1 pending latched after return", r_o, 1);

        // R10 start beats return request
        cyc(1, 1, 16'hF020, 0, 0, 1, 0);
        chk(intr_act == 1'b1 && reti_act == 1'b0, "R10 start priority", intr_act, 1);
        cyc(0, 0, 16'h0, 0, 0, 0, 0);
        chk(mem_wdata == {4'h0, saved}, "R3 restored pc saved again", mem_wdata, saved);
        cyc(); cyc();

        // R7 on and off together
        cyc(0, 0, 16'h0, 1, 1, 0, 0);
        chk(ien_o == 1'b0, "R7 off wins", ien_o, 0);
        cyc(0, 0, 16'h0, 1, 0, 0, 0);
        chk(ien_o == 1'b1, "R7 on alone", ien_o, 1);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic rc, re, ron, rof, ra, rb;
            logic [15:0] rw;
            rc  = ($urandom % 100) < 30;
            re  = ($urandom % 100) < 12;
            rw  = ($urandom % 2) ? 16'hF020 : 16'($urandom);
            ron = ($urandom % 100) < 8;
            rof = ($urandom % 100) < 5;
            ra  = ($urandom % 100) < 10;
            rb  = ($urandom % 100) < 6;
            if (($urandom % 50) == 0) mem[0] = 16'($urandom);
            cyc(rc, re, rw, ron, rof, ra, rb);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
    end
endmodule